// File: doc/BRIEF.md
# Shared-pin key matrix scanner

This block reads a keyboard wired as a matrix of 8 source lines by 4 return lines. It owns no pins of its own for the sources. The first 8 segment outputs of a display driver carry the source levels, and they are borrowed only during a scan slot that the display sequencer hands out once per frame. A frame pulse makes the scanner ask for the slot. Once the slot is granted, the scanner drives one source high at a time and reads the four returns. A pressed key connects its source to its return, so it reads high.

Each scan builds a 32-bit raw picture of the matrix. That picture is compared with the one from the previous valid scan. A key bit reaches the latched image only when two valid scans in a row agree on it. The latched image changes in a single cycle at the end of a scan. The request flag shows whether any key is held in the latched image, and the image is meant to be read only while that flag is high.

The output-enable input qualifies the scan. If it is low at any point during the slot, the returns cannot be trusted, so that scan is thrown away.

Top module: `keyscan_top`

## Requirements
- R1: After reset, key_image is all zero, key_req is low, slot_req is low, and seg_sel_o equals seg_sel_i.
- R2: A frame_start pulse while the scanner is idle raises slot_req on the next cycle. slot_req stays high while the grant is awaited and through the whole scan, and it drops in the cycle after the last sample.
- R3: Once slot_grant is seen high with slot_req high, the scan runs 8 steps of STEP_CYCLES cycles each. During step s (s = 0 for source 1 up to s = 7 for source 8), seg_sel_o equals the value with only bit s set.
- R4: Outside the scan steps, including while waiting for the grant, seg_sel_o equals seg_sel_i.
- R5: key_ret is sampled in the last cycle of each step. A high return r seen during step s is recorded at image bit s*4 + r.
- R6: key_image changes only in the cycle after the final sample of a scan, never partway through a scan.
- R7: A bit of key_image takes a new value only when two consecutive valid scans read that bit the same. A bit on which the two scans disagree keeps its old value.
- R8: key_req is high exactly when at least one bit of key_image is set.
- R9: If oe is low in any cycle of the scan steps, including the final sample cycle, that scan changes neither key_image nor the history that the next scan is compared against.
- R10: A frame_start pulse during a pending request or a running scan is ignored. No further scan follows it once the current scan ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | One-cycle pulse per display frame |
| slot_grant | input | 1 | Scan slot granted by the display sequencer |
| slot_req | output | 1 | Scan slot requested or in use |
| oe | input | 1 | Output enable; a low level voids the current scan |
| seg_sel_i | input | 8 | Level selects of segments 1 to 8 from the display path |
| seg_sel_o | output | 8 | Level selects of segments 1 to 8 after the scan override |
| key_ret | input | 4 | Return lines; high means a key is pressed |
| key_image | output | 32 | Debounced key image, bit = source*4 + return |
| key_req | output | 1 | High when any key is set in the image |

## Verification
Two events can fall in the same cycle: the final sample that commits a scan, and oe dropping low. To provoke this, the bench drives oe low for exactly the last sample cycle of a scan and holds it high everywhere else. It judges the result two ways. First, the image must stay unchanged after that scan. Second, a later valid scan showing the same key pattern must still fail to commit it, which proves the comparison history was left untouched. A frame pulse landing in the middle of a scan is also injected, and the bench checks that no extra slot request follows.

// File: rtl/keyscan_pkg.sv
package keyscan_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_SCAN = 2'd2
    } scan_state_e;

    // Two-scan agreement filter: take raw where it matches history, else hold.
    function automatic logic [63:0] agree_merge(input logic [63:0] held,
                                                input logic [63:0] hist,
                                                input logic [63:0] raw);
        logic [63:0] diff;
        diff = raw ^ hist;
        return (held & diff) | (raw & ~diff);
    endfunction
endpackage

// File: rtl/keyscan_seq.sv
module keyscan_seq
    import keyscan_pkg::*;
#(
    parameter int NUM_SRC     = 8,
    parameter int STEP_CYCLES = 4,
    localparam int SW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int CW = (STEP_CYCLES > 1) ? $clog2(STEP_CYCLES) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          frame_start,
    input  logic          slot_grant,
    output logic          slot_req,
    output logic          scanning,
    output logic [SW-1:0] src_idx,
    output logic          step_last,
    output logic          scan_last
);
    typedef struct packed {
        scan_state_e   st;
        logic [SW-1:0] src;
        logic [CW-1:0] cnt;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        scanning  = (seq_q.st == ST_SCAN);
        slot_req  = (seq_q.st != ST_IDLE);
        src_idx   = seq_q.src;
        step_last = scanning && (seq_q.cnt == CW'(STEP_CYCLES - 1));
        scan_last = step_last && (seq_q.src == SW'(NUM_SRC - 1));
    end

    always_comb begin
        seq_d = seq_q;
        unique case (seq_q.st)
            ST_IDLE: begin
                if (frame_start) seq_d.st = ST_REQ;
            end
            ST_REQ: begin
                if (slot_grant) begin
                    seq_d.st  = ST_SCAN;
                    seq_d.src = '0;
                    seq_d.cnt = '0;
                end
            end
            ST_SCAN: begin
                if (step_last) begin
                    seq_d.cnt = '0;
                    if (scan_last) begin
                        seq_d.st  = ST_IDLE;
                        seq_d.src = '0;
                    end else begin
                        seq_d.src = seq_q.src + 1'b1;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt + 1'b1;
                end
            end
            default: seq_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            seq_q <= '{st: ST_IDLE, src: '0, cnt: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    // R2: the request is held for the whole scan
    p_hold_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
        scanning |-> slot_req);

    // R2: a request only starts from a frame pulse
    p_req_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(slot_req) |-> $past(frame_start));

    // R3: a source is held for its full step
    p_step_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && !step_last) |=> (scanning && $stable(src_idx)));

    // R10: a frame pulse mid-scan cannot restart the scan
    p_no_restart_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (scanning && !scan_last && frame_start) |=> scanning);
endmodule

// File: rtl/keyscan_drive.sv
module keyscan_drive #(
    parameter int NUM_SRC = 8,
    localparam int SW = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scanning,
    input  logic [SW-1:0]      src_idx,
    input  logic [NUM_SRC-1:0] seg_sel_i,
    output logic [NUM_SRC-1:0] seg_sel_o
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_pin
        logic src_hit;
        assign src_hit      = (src_idx == SW'(g));
        assign seg_sel_o[g] = scanning ? src_hit : seg_sel_i[g];
    end

    // R3: exactly one source driven during a scan step
    p_onehot_src_r3: assert property (@(posedge clk) disable iff (!rst_n)
        scanning |-> ($countones(seg_sel_o) == 1));
endmodule

// File: rtl/keyscan_capture.sv
module keyscan_capture
    import keyscan_pkg::*;
#(
    parameter int NUM_SRC = 8,
    parameter int NUM_RET = 4,
    localparam int SW    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int IMG_W = NUM_SRC * NUM_RET
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scanning,
    input  logic [SW-1:0]      src_idx,
    input  logic               step_last,
    input  logic               scan_last,
    input  logic               oe,
    input  logic [NUM_RET-1:0] key_ret,
    output logic [IMG_W-1:0]   key_image,
    output logic               key_req
);
    typedef struct packed {
        logic [IMG_W-1:0] raw;
        logic [IMG_W-1:0] hist;
        logic [IMG_W-1:0] img;
        logic             oe_ok;
        logic             req;
    } cap_t;

    cap_t cap_d, cap_q;
    logic [IMG_W-1:0] raw_full;
    logic             commit;

    always_comb begin
        raw_full = cap_q.raw;
        for (int s = 0; s < NUM_SRC; s++) begin
            if (src_idx == SW'(s)) raw_full[s*NUM_RET +: NUM_RET] = key_ret;
        end
        commit = scan_last && cap_q.oe_ok && oe;

        cap_d       = cap_q;
        cap_d.oe_ok = scanning ? (cap_q.oe_ok && oe) : 1'b1;
        if (step_last) cap_d.raw = raw_full;
        if (commit) begin
            cap_d.hist = raw_full;
            cap_d.img  = IMG_W'(agree_merge(64'(cap_q.img), 64'(cap_q.hist),
                                            64'(raw_full)));
        end
        cap_d.req = |cap_d.img;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cap_q <= '{raw: '0, hist: '0, img: '0, oe_ok: 1'b1, req: 1'b0};
        end else begin
            cap_q <= cap_d;
        end
    end

    assign key_image = cap_q.img;
    assign key_req   = cap_q.req;

    // R6: image moves only after a committing final sample
    p_atomic_img_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(key_image));

    // R9: enable low at the final sample voids the scan
    p_void_last_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_last && !oe) |=> $stable(key_image));

    // R8: request flag changes only with a commit
    p_req_follow_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !commit |=> $stable(key_req));

    // R8: flag agrees with image
    p_req_match_r8: assert property (@(posedge clk) disable iff (!rst_n)
        key_req == (key_image != '0));
endmodule

// File: rtl/keyscan_top.sv
module keyscan_top #(
    parameter int NUM_SRC     = 8,
    parameter int NUM_RET     = 4,
    parameter int STEP_CYCLES = 4,
    localparam int SW    = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1,
    localparam int IMG_W = NUM_SRC * NUM_RET
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               frame_start,
    input  logic               slot_grant,
    output logic               slot_req,
    input  logic               oe,
    input  logic [NUM_SRC-1:0] seg_sel_i,
    output logic [NUM_SRC-1:0] seg_sel_o,
    input  logic [NUM_RET-1:0] key_ret,
    output logic [IMG_W-1:0]   key_image,
    output logic               key_req
);
    logic          scanning;
    logic [SW-1:0] src_idx;
    logic          step_last;
    logic          scan_last;

    keyscan_seq #(.NUM_SRC(NUM_SRC), .STEP_CYCLES(STEP_CYCLES)) seq_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .slot_grant(slot_grant), .slot_req(slot_req), .scanning(scanning),
        .src_idx(src_idx), .step_last(step_last), .scan_last(scan_last)
    );

    keyscan_drive #(.NUM_SRC(NUM_SRC)) drive_i (
        .clk(clk), .rst_n(rst_n), .scanning(scanning), .src_idx(src_idx),
        .seg_sel_i(seg_sel_i), .seg_sel_o(seg_sel_o)
    );

    keyscan_capture #(.NUM_SRC(NUM_SRC), .NUM_RET(NUM_RET)) cap_i (
        .clk(clk), .rst_n(rst_n), .scanning(scanning), .src_idx(src_idx),
        .step_last(step_last), .scan_last(scan_last), .oe(oe),
        .key_ret(key_ret), .key_image(key_image), .key_req(key_req)
    );

    // R4: display path untouched outside the scan
    p_pass_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !scanning |-> (seg_sel_o == seg_sel_i));
endmodule

// File: tb/keyscan_top_tb_top.sv
`timescale 1ns/1ps
module keyscan_top_tb_top;
    localparam int NS = 8;
    localparam int NR = 4;
    localparam int SC = 4;
    localparam int IW = NS * NR;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          frame_start = 1'b0;
    logic          slot_grant = 1'b0;
    logic          slot_req;
    logic          oe = 1'b1;
    logic [NS-1:0] seg_sel_i = '0;
    logic [NS-1:0] seg_sel_o;
    logic [NR-1:0] key_ret;
    logic [IW-1:0] key_image;
    logic          key_req;
    logic [IW-1:0] pressed = '0;

    int errors = 0;
    int checks = 0;
    bit done   = 1'b0;
    logic [IW-1:0] exp_img  = '0;
    logic [IW-1:0] exp_hist = '0;

    always #2 clk = ~clk;

    keyscan_top #(.NUM_SRC(NS), .NUM_RET(NR), .STEP_CYCLES(SC)) dut_i (
        .clk(clk), .rst_n(rst_n), .frame_start(frame_start),
        .slot_grant(slot_grant), .slot_req(slot_req), .oe(oe),
        .seg_sel_i(seg_sel_i), .seg_sel_o(seg_sel_o), .key_ret(key_ret),
        .key_image(key_image), .key_req(key_req)
    );

    // Key matrix model: a pressed key ties its source to its return.
    always_comb begin
        key_ret = '0;
        for (int s = 0; s < NS; s++)
            for (int r = 0; r < NR; r++)
                if (seg_sel_o[s] && pressed[s*NR + r]) key_ret[r] = 1'b1;
    end

    function automatic logic [IW-1:0] merge(logic [IW-1:0] img,
                                            logic [IW-1:0] hist,
                                            logic [IW-1:0] raw);
        return (img & (raw ^ hist)) | (raw & ~(raw ^ hist));
    endfunction

    task automatic chk(input bit ok, input string req,
                       input logic [IW-1:0] act, input logic [IW-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Runs one slot. oe is held low at scan-relative negedge k == oe_low_k.
    task automatic run_scan(input int oe_low_k, input bit mid_pulse,
                            input int grant_delay);
        int last_k;
        int k0;
        bit valid;
        last_k = 1 + grant_delay + NS * SC;
        k0     = 2 + grant_delay;
        valid  = 1'b1;
        @(negedge clk);
        frame_start = 1'b1;
        slot_grant  = (grant_delay == 0);
        for (int k = 1; k <= last_k + 1; k++) begin
            @(negedge clk);
            frame_start = (mid_pulse && k == k0 + 9);
            if (k == 1) chk(slot_req == 1'b1, "R2 req raised", IW'(slot_req), 1);
            if (k < k0) begin
                chk(seg_sel_o == seg_sel_i, "R4 pass while waiting",
                    IW'(seg_sel_o), IW'(seg_sel_i));
                if (k == k0 - 1) slot_grant = 1'b1;
            end else if (k <= last_k) begin
                chk(seg_sel_o == NS'(1 << ((k - k0) / SC)), "R3 source pattern",
                    IW'(seg_sel_o), IW'(1 << ((k - k0) / SC)));
                chk(key_image == exp_img, "R6 image stable mid-scan",
                    key_image, exp_img);
                chk(slot_req == 1'b1, "R2 req held", IW'(slot_req), 1);
                oe = (k != oe_low_k);
                if (!oe) valid = 1'b0;
            end else begin
                oe = 1'b1;
                slot_grant = 1'b0;
                if (valid) begin
                    exp_img  = merge(exp_img, exp_hist, pressed);
                    exp_hist = pressed;
                end
                chk(slot_req == 1'b0, "R2 req dropped", IW'(slot_req), 0);
                chk(key_image == exp_img, valid ? "R5 R7 image" : "R9 void scan",
                    key_image, exp_img);
                chk(key_req == (exp_img != '0), "R8 request flag",
                    IW'(key_req), IW'(exp_img != '0));
                chk(seg_sel_o == seg_sel_i, "R4 pass after scan",
                    IW'(seg_sel_o), IW'(seg_sel_i));
            end
        end
        for (int j = 0; j < 3; j++) begin
            @(negedge clk);
            chk(slot_req == 1'b0, "R10 no extra request", IW'(slot_req), 0);
        end
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED));
        seg_sel_i = 8'hA5;
        #1;
        chk(key_image == '0, "R1 reset image", key_image, '0);
        chk(key_req == 1'b0, "R1 reset req", IW'(key_req), 0);
        chk(slot_req == 1'b0, "R1 reset slot", IW'(slot_req), 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        chk(seg_sel_o == seg_sel_i, "R1 reset pass", IW'(seg_sel_o), IW'(seg_sel_i));
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            seg_sel_i = NS'($urandom);
            #1;
            chk(seg_sel_o == seg_sel_i, "R4 idle pass", IW'(seg_sel_o), IW'(seg_sel_i));
        end

        // R5/R7: single key, source 3 return 4 -> bit 2*4+3 = 11
        pressed = IW'(1) << 11;
        run_scan(-1, 1'b0, 0);
        chk(key_image == '0, "R7 first scan holds", key_image, '0);
        run_scan(-1, 1'b0, 3);
        chk(key_image == (IW'(1) << 11), "R5 bit index", key_image, IW'(1) << 11);

        // R9: oe low in final sample cycle, new pattern
        pressed = 32'h8000_0001;
        run_scan(1 + NS * SC, 1'b0, 0);
        run_scan(-1, 1'b0, 0);
        chk(key_image == (IW'(1) << 11), "R9 history untouched",
            key_image, IW'(1) << 11);
        run_scan(-1, 1'b0, 0);
        // R9: oe low mid-scan, R10: frame pulse mid-scan
        pressed = '0;
        run_scan(12, 1'b1, 1);
        run_scan(-1, 1'b1, 0);
        run_scan(-1, 1'b0, 0);
        chk(key_req == 1'b0, "R8 all released", IW'(key_req), 0);

        for (int i = 0; i < 24; i++) begin
            if ($urandom_range(2) != 0) pressed = IW'($urandom) & IW'($urandom);
            seg_sel_i = NS'($urandom);
            run_scan(($urandom_range(7) == 0) ? int'($urandom_range(NS * SC) + 1) : -1,
                     $urandom_range(3) == 0, int'($urandom_range(2)));
        end

        done = 1'b1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule